// File: doc/BRIEF.md
# Global-History Correlating Branch Predictor

This block predicts the direction of conditional branches. A table of saturating counters is indexed by a few low-order bits of the branch address. Each table row holds one counter per possible value of a global outcome history. The history is a short shift register that records the directions of the most recently resolved branches, and its current value picks which counter in the row is used. Branches that behave differently depending on what the branches before them did can therefore be trained on separate counters.

The fetch side presents a PC and receives a taken/not-taken guess in the same cycle. The guess is taken from the selected counter's most significant bit. The fetch side also sees the history value that was used, so it can carry that value along with the branch. When the branch resolves, the back end returns the PC, the real direction and the carried history. The block then nudges that one counter toward the real direction and shifts the real direction into the history.

Rows carry no tag, so unrelated branches that share index bits also share counters. With the history length set to zero, every row holds a single counter and the block is a plain address-indexed counter table.

Top module: `corr_bpred`

## Requirements
- R1: On a cycle with `up_valid` high, the history shifts one place toward its MSB, `up_taken` (1 = taken) enters bit 0 and the oldest bit is dropped. The new value appears on `lk_ghist` from the next cycle.
- R2: On a cycle with `up_valid` low, the history keeps its value.
- R3: The row is chosen by PC bits [PC_LSB+IDX_W-1:PC_LSB]. Within the row, the counter is chosen by the history value: the current history for a lookup, and `up_ghist` for an update.
- R4: An update changes only the one counter picked by its row and `up_ghist`. Other counters in the same row and all other rows keep their values.
- R5: No tag is compared, so PCs that differ only outside the index bits read and train the same counters.
- R6: Counters are CTR_W bits wide and move one step toward the resolved direction. They saturate at 0 and 2^CTR_W-1 and never wrap.
- R7: `lk_pred` equals the MSB of the selected counter and follows `lk_pc` in the same cycle, with no clock edge in between.
- R8: Synchronous reset sets every counter to 2^(CTR_W-1)-1 (weakly not taken, so `lk_pred` = 0) and clears the history to zero.
- R9: When a lookup and an update hit the same counter in one cycle, the lookup returns the value from before the update. The trained value is seen from the next cycle.
- R10: With HIST_BITS = 0, each row has a single counter and predictions ignore the history entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | Fetch address to predict |
| lk_pred | output | 1 | Predicted direction, 1 = taken |
| lk_ghist | output | max(HIST_BITS,1) | History value used by the current lookup |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual direction, 1 = taken |
| up_ghist | input | max(HIST_BITS,1) | History that was used when this branch was predicted |

## Verification
The checker assumes that reset is held for at least one clock edge before anything is observed. It also assumes that `lk_pc` is free of unknowns whenever reset is low. Its prediction-stability property only applies to cycles in which the fetch address did not move and no update landed. The stimulus changes every input only on the falling clock edge, so each rising edge sees stable, defined values. The stimulus passes back arbitrary history values on updates, including values that differ from the live history; the block accepts any value there. The stimulus also keeps the history length at least two on the main instance, so that the shift property's upper-bit check is meaningful.

// File: rtl/bp_corr_pkg.sv
package bp_corr_pkg;

  typedef enum logic {
    OUT_NT = 1'b0,
    OUT_T  = 1'b1
  } outcome_e;

  function automatic int unsigned hist_port_w(int unsigned m);
    return (m > 0) ? m : 1;
  endfunction

endpackage

// File: rtl/bp_ghist.sv
module bp_ghist
  import bp_corr_pkg::*;
#(
  parameter int HIST_BITS = 2,
  localparam int HW = hist_port_w(HIST_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  outcome_e      din,
  output logic [HW-1:0] hist
);

  generate
    if (HIST_BITS == 0) begin : g_none
      logic unused_in;
      assign unused_in = clk ^ rst ^ shift_en ^ din;
      assign hist = '0;
    end else if (HIST_BITS == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst)
          hist <= '0;
        else if (shift_en)
          hist <= din;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (rst)
          hist <= '0;
        else if (shift_en)
          hist <= {hist[HW-2:0], din};
      end
    end
  endgenerate

endmodule

// File: rtl/bp_addr.sv
module bp_addr
  import bp_corr_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2,
  parameter int IDX_W     = 4,
  parameter int HIST_BITS = 2,
  localparam int HW = hist_port_w(HIST_BITS),
  localparam int AW = IDX_W + HIST_BITS
) (
  input  logic [PC_W-1:0] pc,
  input  logic [HW-1:0]   hist,
  output logic [AW-1:0]   addr
);

  logic [IDX_W-1:0] row;
  logic             unused_pc;

  assign row       = pc[PC_LSB +: IDX_W];
  assign unused_pc = ^pc;

  generate
    if (HIST_BITS == 0) begin : g_flat
      logic unused_hist;
      assign unused_hist = ^hist;
      assign addr = row;
    end else begin : g_corr
      assign addr = {row, hist};
    end
  endgenerate

endmodule

// File: rtl/bp_ctr_bank.sv
module bp_ctr_bank
  import bp_corr_pkg::*;
#(
  parameter int AW    = 6,
  parameter int CTR_W = 2,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    rd_addr,
  output logic [CTR_W-1:0] rd_ctr,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  outcome_e         wr_dir,
  output logic [CTR_W-1:0] wr_old,
  output logic [CTR_W-1:0] wr_new
);

  localparam logic [CTR_W-1:0] C_MAX  = '1;
  localparam logic [CTR_W-1:0] C_INIT = C_MAX >> 1;
  localparam logic [CTR_W-1:0] C_ONE  = {{(CTR_W-1){1'b0}}, 1'b1};

  logic [CTR_W-1:0] ctr_q [DEPTH];

  assign rd_ctr = ctr_q[rd_addr];
  assign wr_old = ctr_q[wr_addr];

  always_comb begin
    wr_new = wr_old;
    if (wr_dir == OUT_T) begin
      if (wr_old != C_MAX) wr_new = wr_old + C_ONE;
    end else begin
      if (wr_old != '0) wr_new = wr_old - C_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= C_INIT;
    end else if (wr_en) begin
      ctr_q[wr_addr] <= wr_new;
    end
  end

endmodule

// File: rtl/corr_bpred.sv
module corr_bpred
  import bp_corr_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2,
  parameter int IDX_W     = 4,
  parameter int HIST_BITS = 2,
  parameter int CTR_W     = 2,
  localparam int HW = hist_port_w(HIST_BITS),
  localparam int AW = IDX_W + HIST_BITS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_pred,
  output logic [HW-1:0]   lk_ghist,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic [HW-1:0]   up_ghist
);

  logic [AW-1:0]    lk_addr;
  logic [AW-1:0]    up_addr;
  logic [CTR_W-1:0] lk_ctr;
  logic [CTR_W-1:0] upd_old;
  logic [CTR_W-1:0] upd_new;
  outcome_e         up_dir;

  assign up_dir = outcome_e'(up_taken);

  bp_ghist #(.HIST_BITS(HIST_BITS)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (up_valid),
    .din      (up_dir),
    .hist     (lk_ghist)
  );

  bp_addr #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .HIST_BITS(HIST_BITS)) u_lk_addr (
    .pc   (lk_pc),
    .hist (lk_ghist),
    .addr (lk_addr)
  );

  bp_addr #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .HIST_BITS(HIST_BITS)) u_up_addr (
    .pc   (up_pc),
    .hist (up_ghist),
    .addr (up_addr)
  );

  bp_ctr_bank #(.AW(AW), .CTR_W(CTR_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (lk_addr),
    .rd_ctr  (lk_ctr),
    .wr_en   (up_valid),
    .wr_addr (up_addr),
    .wr_dir  (up_dir),
    .wr_old  (upd_old),
    .wr_new  (upd_new)
  );

  assign lk_pred = lk_ctr[CTR_W-1];

endmodule

// File: rtl/bp_corr_chk.sv
module bp_corr_chk
  import bp_corr_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int HIST_BITS = 2,
  parameter int CTR_W     = 2,
  localparam int HW = hist_port_w(HIST_BITS)
) (
  input logic             clk,
  input logic             rst,
  input logic [PC_W-1:0]  lk_pc,
  input logic             lk_pred,
  input logic [HW-1:0]    lk_ghist,
  input logic             up_valid,
  input logic             up_taken,
  input logic [CTR_W-1:0] upd_old,
  input logic [CTR_W-1:0] upd_new
);

  // R1: newest outcome lands in bit 0
  generate
    if (HIST_BITS > 0) begin : g_lsb
      a_r1_hist_newest: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && up_valid) |=> (lk_ghist[0] == $past(up_taken)));
    end
    if (HIST_BITS > 1) begin : g_upper
      a_r1_hist_shift: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && up_valid) |=> (lk_ghist[HW-1:1] == $past(lk_ghist[HW-2:0])));
    end
  endgenerate

  a_r2_hist_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !up_valid) |=> $stable(lk_ghist));

  // R6: saturating, never wraps
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
    up_valid |-> !((upd_old == '1) && (upd_new == '0)) && !((upd_old == '0) && (upd_new == '1)));

  // R7: prediction moves only when the address or trained state moves
  a_r7_pred_stable: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(lk_pc) && !$past(up_valid)) |-> $stable(lk_pred));

endmodule

bind corr_bpred bp_corr_chk #(.PC_W(PC_W), .HIST_BITS(HIST_BITS), .CTR_W(CTR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .lk_pc    (lk_pc),
  .lk_pred  (lk_pred),
  .lk_ghist (lk_ghist),
  .up_valid (up_valid),
  .up_taken (up_taken),
  .upd_old  (upd_old),
  .upd_new  (upd_new)
);

// File: tb/sim_corr_bpred.sv
module sim_corr_bpred;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        uv;
    logic [31:0] upc;
    logic        ut;
    logic [1:0]  ugh;
    logic [31:0] lpc;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b1, 32'h0000_0010, 1'b1, 2'd0, 32'h0000_0010},
    '{1'b1, 32'h0000_0010, 1'b1, 2'd0, 32'h0000_0010},
    '{1'b0, 32'h0000_0000, 1'b0, 2'd0, 32'h0000_0010},
    '{1'b1, 32'h0000_0024, 1'b0, 2'd2, 32'h0000_0024},
    '{1'b1, 32'h0000_0024, 1'b1, 2'd1, 32'h0000_003C},
    '{1'b0, 32'h0000_0000, 1'b0, 2'd0, 32'h0000_0024},
    '{1'b1, 32'h0000_003C, 1'b1, 2'd3, 32'h0000_003C},
    '{1'b1, 32'h0000_003C, 1'b1, 2'd3, 32'h0000_003C},
    '{1'b0, 32'h0000_0000, 1'b0, 2'd0, 32'h0000_003C},
    '{1'b1, 32'h0000_0008, 1'b0, 2'd1, 32'h0000_0008},
    '{1'b1, 32'h0000_0008, 1'b1, 2'd3, 32'h0000_0010},
    '{1'b0, 32'h0000_0000, 1'b0, 2'd0, 32'h0000_0008}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] lk_pc;
  logic        pred0, pred1;
  logic [1:0]  gh0;
  logic [0:0]  gh1;
  logic        up_valid;
  logic [31:0] up_pc;
  logic        up_taken;
  logic [1:0]  up_ghist;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  int mc [64];
  int mf [16];
  int ghr;
  bit prev_uv;

  always #(CLK_PERIOD/2) clk = ~clk;

  corr_bpred u0 (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_pred(pred0), .lk_ghist(gh0),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_ghist(up_ghist)
  );

  corr_bpred #(.HIST_BITS(0)) u1 (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_pred(pred1), .lk_ghist(gh1),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_ghist(1'b0)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sat(int c, bit t);
    if (t) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 64; i++) mc[i] = 1;
    for (int i = 0; i < 16; i++) mf[i] = 1;
    ghr = 0;
    prev_uv = 0;
  endtask

  // Called at a falling edge; leaves at the next falling edge.
  task automatic step(bit uv, logic [31:0] upc, bit ut, logic [1:0] ugh,
                      logic [31:0] lpc, string tag);
    int li, ui;
    up_valid = uv; up_pc = upc; up_taken = ut; up_ghist = ugh; lk_pc = lpc;
    #1;
    li = int'(lpc[5:2]);
    check(tag, int'(pred0), (mc[li*4 + ghr] >= 2) ? 1 : 0);
    check("R10", int'(pred1), (mf[li] >= 2) ? 1 : 0);
    check(prev_uv ? "R1" : "R2", int'(gh0), ghr);
    @(posedge clk);
    if (uv) begin
      ui = int'(upc[5:2]);
      mc[ui*4 + int'(ugh)] = sat(mc[ui*4 + int'(ugh)], ut);
      mf[ui] = sat(mf[ui], ut);
      ghr = ((ghr << 1) | int'(ut)) & 3;
    end
    prev_uv = uv;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; up_valid = 0; up_pc = '0; up_taken = 0; up_ghist = '0; lk_pc = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R8: reset state, several rows
    step(0, 0, 0, 0, 32'h0000_0000, "R8");
    step(0, 0, 0, 0, 32'h0000_0034, "R8");
    step(0, 0, 0, 0, 32'h0000_003C, "R8");

    // Table walk: R3 row/slot selection, R7 combinational prediction
    foreach (VEC[k]) step(VEC[k].uv, VEC[k].upc, VEC[k].ut, VEC[k].ugh, VEC[k].lpc,
                          (k % 2 == 0) ? "R3" : "R7");

    // R6: drive row 0 slot 0 up to the ceiling, then bring history to 0
    for (int k = 0; k < 4; k++) step(1, 32'h0000_0040, 1, 2'd0, 32'h0000_0040, "R6");
    step(1, 32'h0000_0088, 0, 2'd1, 32'h0000_0040, "R6");
    step(1, 32'h0000_0088, 0, 2'd1, 32'h0000_0040, "R6");
    for (int k = 0; k < 5; k++) step(1, 32'h0000_0040, 0, 2'd0, 32'h0000_0040, "R6");
    step(0, 0, 0, 0, 32'h0000_0040, "R6");

    // R9: history at 3, train and look up the same counter together
    step(1, 32'h0000_0014, 1, 2'd0, 32'h0000_0014, "R9");
    step(1, 32'h0000_0014, 1, 2'd0, 32'h0000_0014, "R9");
    step(1, 32'h0000_0030, 1, 2'd3, 32'h0000_0030, "R9");
    step(0, 0, 0, 0, 32'h0000_0030, "R9");

    // R4: neighbour slot in the same row is untouched (history becomes 2)
    step(1, 32'h0000_0014, 0, 2'd0, 32'h0000_0014, "R4");
    step(0, 0, 0, 0, 32'h0000_0030, "R4");
    step(1, 32'h0000_0020, 1, 2'd2, 32'h0000_0030, "R4");
    step(0, 0, 0, 0, 32'h0000_0034, "R4");

    // R5: alias above the index bits shares the trained counter
    step(1, 32'h0000_0014, 1, 2'd0, 32'h0000_0070, "R5");
    step(0, 0, 0, 0, 32'h0000_0070, "R5");
    step(1, 32'h0000_5030, 1, 2'd3, 32'h0000_1070, "R5");
    step(0, 0, 0, 0, 32'h0000_0030, "R5");

    // R8: reset again mid-run
    up_valid = 0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    step(0, 0, 0, 0, 32'h0000_0030, "R8");
    step(0, 0, 0, 0, 32'h0000_0010, "R8");

    done = 1;
    summary();
    $finish;
  end

endmodule